// File: doc/BRIEF.md
# Load Effective Address Unit

This unit forms the memory address for a fixed-point load. It takes the instruction format, the update flag, the target and base register indices, the values read from the base and index registers and the raw 16-bit displacement field. From these it produces a 64-bit effective address. It also decides whether the base register must be overwritten with that address and whether the update encoding is illegal.

The base is either the base register value or a literal zero. A zero base applies only to non-update loads whose base index is 0. The offset is either a scaled, sign-extended displacement or the full index register value. The sum wraps at 64 bits. Results leave through a one-cycle register stage with a valid strobe, so the unit can sit between operand read and the memory access stage of a pipeline. A parameter removes the stage and leaves a purely combinational path.

Top module: `lea_unit`

## Requirements
- R1: In a non-update load (`upd_i`=0), a base index of 0 selects a base of zero. Any other base index selects `ra_val_i` as the base.
- R2: In an update load (`upd_i`=1), the base is always `ra_val_i`, including when the base index is 0.
- R3: With format code 0 (16-bit displacement), the address is the base plus `disp_i` sign-extended from bit 15.
- R4: With format code 1 (word-scaled displacement), bits 1:0 of `disp_i` are replaced by zero and the 16-bit result is sign-extended. The offset is therefore a multiple of 4, and bits 1:0 of `disp_i` have no effect.
- R5: With format code 2 (16-byte-scaled displacement), bits 3:0 of `disp_i` are replaced by zero and the 16-bit result is sign-extended. The offset is therefore a multiple of 16, and bits 3:0 of `disp_i` have no effect.
- R6: With format code 3 (indexed), the address is the base plus `rb_val_i`, and `disp_i` has no effect.
- R7: `bad_form_o` is 1 for an update load whose base index is 0 or equals the target index. It is 0 for every non-update load.
- R8: `wb_en_o` is 1 only for an update load that is not flagged by R7. When `bad_form_o` is 1, `wb_en_o` is 0. The address is reported on `ea_o` in every case.
- R9: The addition wraps modulo 2^64. There is no carry or overflow output.
- R10: With the default register stage, `out_valid_o` is `in_valid_i` delayed by one clock. `ea_o`, `wb_en_o` and `bad_form_o` belong to that request. `wb_en_o` and `bad_form_o` are 0 whenever `out_valid_o` is 0.
- R11: While `rst` is high, and in the cycle after it, `out_valid_o`, `wb_en_o`, `bad_form_o` and `ea_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request valid |
| form_i | input | 2 | Format code: 0 displacement, 1 word-scaled, 2 16-byte-scaled, 3 indexed |
| upd_i | input | 1 | Update form: write the address back into the base register |
| rt_idx_i | input | 5 | Target register index |
| ra_idx_i | input | 5 | Base register index |
| ra_val_i | input | 64 | Base register contents |
| rb_val_i | input | 64 | Index register contents |
| disp_i | input | 16 | Raw displacement field |
| out_valid_o | output | 1 | Result valid |
| ea_o | output | 64 | Effective address, also the write-back value |
| wb_en_o | output | 1 | Write `ea_o` into the base register |
| bad_form_o | output | 1 | Illegal update encoding |

## Verification
Two functions can act on the same request: zero-base substitution for index 0 and illegal-update detection. Both apply when an update load names base index 0. The same holds for base-register write-back and illegal-form detection when the base index equals the target index. The bench provokes both collisions with update loads carrying a non-zero `ra_val_i`. It judges them by checking three things: the address still uses `ra_val_i` rather than zero, `bad_form_o` rises, and `wb_en_o` stays low in that same output cycle. It also checks that a legal update issued directly afterwards raises `wb_en_o`.

// File: rtl/lea_pkg.sv
package lea_pkg;

    parameter int XLEN   = 64;
    parameter int IDX_W  = 5;
    parameter int DISP_W = 16;
    parameter int WS_LOW = 2;   // low bits cleared in word-scaled format
    parameter int QS_LOW = 4;   // low bits cleared in 16-byte-scaled format

    typedef enum logic [1:0] {
        FMT_DISP  = 2'd0,
        FMT_WSCL  = 2'd1,
        FMT_QSCL  = 2'd2,
        FMT_INDEX = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [XLEN-1:0] ea;
        logic            wb_en;
        logic            bad;
    } lea_res_t;

    function automatic logic [XLEN-1:0] sext_disp(input logic [DISP_W-1:0] v);
        return {{(XLEN-DISP_W){v[DISP_W-1]}}, v};
    endfunction

    function automatic logic [DISP_W-1:0] clear_low(input logic [DISP_W-1:0] v,
                                                    input int unsigned  n);
        logic [DISP_W-1:0] m;
        m = '1;
        m = m << n;
        return v & m;
    endfunction

endpackage

// File: rtl/lea_base_sel.sv
module lea_base_sel
    import lea_pkg::*;
(
    input  logic             upd_i,
    input  logic [IDX_W-1:0] ra_idx_i,
    input  logic [XLEN-1:0]  ra_val_i,
    output logic [XLEN-1:0]  base_o
);
    logic zero_base;

    // Literal zero only for non-update forms naming index 0 (R1, R2)
    assign zero_base = !upd_i && (ra_idx_i == '0);

    always_comb begin
        base_o = zero_base ? '0 : ra_val_i;
    end
endmodule

// File: rtl/lea_offset_gen.sv
module lea_offset_gen
    import lea_pkg::*;
(
    input  fmt_e              fmt_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [XLEN-1:0]   rb_val_i,
    output logic [XLEN-1:0]   off_o
);
    logic [DISP_W-1:0] ws_field;
    logic [DISP_W-1:0] qs_field;

    assign ws_field = clear_low(disp_i, WS_LOW);
    assign qs_field = clear_low(disp_i, QS_LOW);

    always_comb begin
        unique case (fmt_i)
            FMT_DISP:  off_o = sext_disp(disp_i);
            FMT_WSCL:  off_o = sext_disp(ws_field);
            FMT_QSCL:  off_o = sext_disp(qs_field);
            default:   off_o = rb_val_i;
        endcase
    end

    always_comb begin
        if (fmt_i == FMT_WSCL)
            assert (off_o[WS_LOW-1:0] == '0) else $error("AST_WS_ALIGN"); // R4
        if (fmt_i == FMT_QSCL)
            assert (off_o[QS_LOW-1:0] == '0) else $error("AST_QS_ALIGN"); // R5
    end
endmodule

// File: rtl/lea_form_check.sv
module lea_form_check
    import lea_pkg::*;
(
    input  logic             upd_i,
    input  logic [IDX_W-1:0] rt_idx_i,
    input  logic [IDX_W-1:0] ra_idx_i,
    output logic             bad_o,
    output logic             wb_o
);
    logic idx_zero;
    logic idx_alias;

    assign idx_zero  = (ra_idx_i == '0);
    assign idx_alias = (ra_idx_i == rt_idx_i);

    always_comb begin
        bad_o = upd_i && (idx_zero || idx_alias);
        wb_o  = upd_i && !bad_o;
    end
endmodule

// File: rtl/lea_unit.sv
module lea_unit
    import lea_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [1:0]        form_i,
    input  logic              upd_i,
    input  logic [IDX_W-1:0]  rt_idx_i,
    input  logic [IDX_W-1:0]  ra_idx_i,
    input  logic [XLEN-1:0]   ra_val_i,
    input  logic [XLEN-1:0]   rb_val_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              out_valid_o,
    output logic [XLEN-1:0]   ea_o,
    output logic              wb_en_o,
    output logic              bad_form_o
);
    fmt_e            fmt;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic            bad_c;
    logic            wb_c;
    lea_res_t        res_c;

    assign fmt = fmt_e'(form_i);

    lea_base_sel u_base (
        .upd_i    (upd_i),
        .ra_idx_i (ra_idx_i),
        .ra_val_i (ra_val_i),
        .base_o   (base)
    );

    lea_offset_gen u_off (
        .fmt_i    (fmt),
        .disp_i   (disp_i),
        .rb_val_i (rb_val_i),
        .off_o    (offset)
    );

    lea_form_check u_chk (
        .upd_i    (upd_i),
        .rt_idx_i (rt_idx_i),
        .ra_idx_i (ra_idx_i),
        .bad_o    (bad_c),
        .wb_o     (wb_c)
    );

    // Modulo 2^XLEN sum, carry discarded (R9)
    always_comb begin
        res_c.ea    = base + offset;
        res_c.wb_en = in_valid_i && wb_c;
        res_c.bad   = in_valid_i && bad_c;
    end

    generate
        if (REG_OUT) begin : g_reg
            lea_res_t res_q;
            logic     vld_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q       <= in_valid_i;
                    res_q.wb_en <= res_c.wb_en;
                    res_q.bad   <= res_c.bad;
                    if (in_valid_i)
                        res_q.ea <= res_c.ea;
                end
            end

            assign out_valid_o = vld_q;
            assign ea_o        = res_q.ea;
            assign wb_en_o     = res_q.wb_en;
            assign bad_form_o  = res_q.bad;

            AST_WB_LEGAL: assert property (@(posedge clk) disable iff (rst)
                wb_en_o |-> ($past(upd_i) && $past(ra_idx_i) != '0
                             && $past(ra_idx_i) != $past(rt_idx_i))); // R8
            AST_BAD_NEEDS_UPD: assert property (@(posedge clk) disable iff (rst)
                bad_form_o |-> $past(upd_i)); // R7
            AST_WB_BAD_EXCL: assert property (@(posedge clk) disable iff (rst)
                !(wb_en_o && bad_form_o)); // R8
            AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
                (wb_en_o || bad_form_o) |-> out_valid_o); // R10
            AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst)
                $rose(out_valid_o) |-> $past(in_valid_i)); // R10
            AST_ZERO_BASE_INDEX: assert property (@(posedge clk) disable iff (rst)
                (out_valid_o && $past(form_i == 2'(FMT_INDEX) && !upd_i && ra_idx_i == '0))
                |-> (ea_o == $past(rb_val_i))); // R1
            AST_QS_ZERO_BASE: assert property (@(posedge clk) disable iff (rst)
                (out_valid_o && $past(form_i == 2'(FMT_QSCL) && !upd_i && ra_idx_i == '0))
                |-> (ea_o[QS_LOW-1:0] == '0)); // R5
        end else begin : g_comb
            assign out_valid_o = in_valid_i;
            assign ea_o        = res_c.ea;
            assign wb_en_o     = res_c.wb_en;
            assign bad_form_o  = res_c.bad;
        end
    endgenerate
endmodule

// File: tb/lea_unit_tb.sv
`timescale 1ns/1ps
module lea_unit_tb_top;
    localparam int XL = 64;

    typedef struct {
        logic [XL-1:0] ea;
        logic          wb;
        logic          bad;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid_i = 1'b0;
    logic [1:0]    form_i = 2'd0;
    logic          upd_i = 1'b0;
    logic [4:0]    rt_idx_i = '0;
    logic [4:0]    ra_idx_i = '0;
    logic [XL-1:0] ra_val_i = '0;
    logic [XL-1:0] rb_val_i = '0;
    logic [15:0]   disp_i = '0;
    logic          out_valid_o;
    logic [XL-1:0] ea_o;
    logic          wb_en_o;
    logic          bad_form_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    lea_unit dut_i (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .form_i(form_i),
        .upd_i(upd_i), .rt_idx_i(rt_idx_i), .ra_idx_i(ra_idx_i),
        .ra_val_i(ra_val_i), .rb_val_i(rb_val_i), .disp_i(disp_i),
        .out_valid_o(out_valid_o), .ea_o(ea_o), .wb_en_o(wb_en_o),
        .bad_form_o(bad_form_o)
    );

    task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model, written from the requirements
    function automatic exp_t model(input logic [1:0] f, input logic u, input logic [4:0] rt,
                                   input logic [4:0] ra, input logic [XL-1:0] rav,
                                   input logic [XL-1:0] rbv, input logic [15:0] d,
                                   input string tag);
        exp_t e;
        logic signed [XL-1:0] off;
        logic [XL-1:0] b;
        b = (!u && ra == 5'd0) ? '0 : rav;
        case (f)
            2'd0: off = XL'($signed(d));
            2'd1: off = (XL'($signed(d)) >>> 2) * 4;
            2'd2: off = (XL'($signed(d)) >>> 4) * 16;
            default: off = rbv;
        endcase
        e.ea  = b + off;
        e.bad = u && (ra == 5'd0 || ra == rt);
        e.wb  = u && !e.bad;
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [1:0] f, input logic u, input logic [4:0] rt,
                         input logic [4:0] ra, input logic [XL-1:0] rav,
                         input logic [XL-1:0] rbv, input logic [15:0] d, input string tag);
        @(negedge clk);
        in_valid_i = 1'b1; form_i = f; upd_i = u; rt_idx_i = rt; ra_idx_i = ra;
        ra_val_i = rav; rb_val_i = rbv; disp_i = d;
        sb.push_back(model(f, u, rt, ra, rav, rbv, d, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid_i = 1'b0;
            disp_i = 16'hDEAD;
            upd_i = 1'b1;
        end
    endtask

    // Monitor: compares outputs with the queue head after each edge
    always begin
        @(posedge clk);
        #1;
        if (mon_on) begin
            if (out_valid_o) begin
                if (sb.size() == 0) begin
                    chk("R10 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " ea"}, ea_o, e.ea);
                    chk({e.tag, " R8 wb_en"}, XL'(wb_en_o), XL'(e.wb));
                    chk({e.tag, " R7 bad_form"}, XL'(bad_form_o), XL'(e.bad));
                end
            end else begin
                chk("R10 flags low when idle", XL'({wb_en_o, bad_form_o}), '0);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        in_valid_i = 1'b1;   // held during reset, must not leak out
        repeat (3) @(negedge clk);
        chk("R11 reset out_valid", XL'(out_valid_o), '0);
        chk("R11 reset ea", ea_o, '0);
        chk("R11 reset flags", XL'({wb_en_o, bad_form_o}), '0);
        rst = 1'b0;
        in_valid_i = 1'b0;
        @(posedge clk); #1;
        chk("R11 first cycle after reset", XL'({out_valid_o, wb_en_o, bad_form_o}), '0);
        mon_on = 1'b1;

        drive(2'd0, 0, 5'd4, 5'd0, 64'h1234, 64'h0, 16'h0010, "R1 zero base");
        drive(2'd0, 0, 5'd4, 5'd3, 64'h1000, 64'h0, 16'h0010, "R1 reg base");
        drive(2'd0, 0, 5'd4, 5'd3, 64'h1000, 64'h0, 16'hFFF0, "R3 negative disp");
        idle(2);
        drive(2'd1, 0, 5'd4, 5'd3, 64'h100, 64'h0, 16'h0007, "R4 word scale low ignored");
        drive(2'd1, 0, 5'd4, 5'd3, 64'h100, 64'h0, 16'h0004, "R4 word scale");
        drive(2'd1, 0, 5'd4, 5'd3, 64'h100, 64'h0, 16'hFFFF, "R4 word scale negative");
        drive(2'd2, 0, 5'd4, 5'd3, 64'h200, 64'h0, 16'h001F, "R5 quad scale low ignored");
        drive(2'd2, 0, 5'd4, 5'd0, 64'h777, 64'h0, 16'h8009, "R5 quad scale negative zero base");
        idle(1);
        drive(2'd3, 0, 5'd4, 5'd3, 64'h5000, 64'h0123, 16'hFFFF, "R6 indexed disp ignored");
        drive(2'd3, 0, 5'd4, 5'd0, 64'h5000, 64'h0123, 16'h1234, "R6 R1 indexed zero base");
        drive(2'd3, 0, 5'd4, 5'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 16'h0, "R9 wrap");
        drive(2'd0, 0, 5'd4, 5'd3, 64'h8, 64'h0, 16'hFFF0, "R9 wrap below zero");
        drive(2'd0, 1, 5'd4, 5'd0, 64'h9000, 64'h0, 16'h0020, "R2 R7 update index zero");
        drive(2'd3, 1, 5'd6, 5'd6, 64'hA000, 64'h40, 16'h0, "R7 update alias");
        drive(2'd1, 1, 5'd6, 5'd7, 64'hB000, 64'h0, 16'h0008, "R8 update legal");
        drive(2'd2, 1, 5'd1, 5'd31, 64'hC000, 64'h0, 16'hFFF0, "R8 update legal quad");
        idle(3);
        drive(2'd0, 0, 5'd5, 5'd5, 64'hD000, 64'h0, 16'h0001, "R7 alias ignored without update");
        idle(4);
        chk("R10 queue drained", XL'(sb.size()), '0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule